// File: doc/BRIEF.md
# Tunneled Frame Header Receiver

This block sits behind an Ethernet MAC receive byte stream. Each raw frame is expected to carry a six-byte link header in the place normally held by the destination address. The block captures that header, classifies the frame, and hands the result to two consumers: four per-channel payload outputs and a transmit engine that answers read requests and acknowledges writes.

A Write frame has its payload, which starts after the source address and ethertype, steered byte by byte to the channel named in the header, with start and end markers. When the frame closes cleanly, the block raises an acknowledge request that carries the serial number, the channel and the number of bytes actually forwarded. A Read frame forwards nothing. When it closes cleanly, it raises a read request with its serial number and channel. Poll, Null and unknown frames are absorbed. Frame check sequence handling belongs to the MAC; only its bad-frame flag, given with the last byte, is consumed here.

Top module: `tunnel_hdr_rx`

## Requirements
- R1: During and right after reset, every output is zero: no request pulses, no channel valid, and zero serial, channel and size.
- R2: Header fields are taken from frame byte positions. Positions 0 and 1 hold the serial number, most significant byte first. Position 2 holds the type. In position 3, bits 7:6 give the channel and bit 2 is the error-end flag. Positions 4 and 5 hold the payload size, most significant byte first.
- R3: A type 0x03 (Read) frame that ends without a MAC error raises rd_req_o for exactly one cycle, in the cycle after its last byte is accepted. evt_sn_o and evt_vc_o carry its serial number and channel. None of its bytes are forwarded.
- R4: For a type 0x02 (Write) frame, the bytes from frame position 14 onward are forwarded unchanged on ch_data_o, one cycle after acceptance. Only ch_valid_o bit [channel] is raised.
- R5: The forwarded length equals the smaller of the size field and the number of bytes received from position 14 on. Bytes past the size are ignored.
- R6: ch_sof_o marks the first forwarded byte and ch_eof_o marks the last. ch_eofe_o replaces ch_eof_o on the last byte when the header's error-end flag is set, or when the MAC error arrives with that same byte.
- R7: A Write frame that ends without a MAC error raises ack_req_o for one cycle, in the cycle after its last byte. It carries the serial number, the channel and ack_size_o equal to the forwarded count, which may be zero.
- R8: A frame whose last byte comes with rx_err_i raises neither rd_req_o nor ack_req_o.
- R9: A size field above 8192 drops the frame: nothing is forwarded and no request is raised. A size of exactly 8192 is accepted.
- R10: A frame shorter than 14 bytes raises no request and forwards nothing. A 14-byte Read frame is accepted.
- R11: Types 0x00 (Null), 0x01 (Poll) and any other code produce no request and no forwarded byte.
- R12: Idle cycles with rx_valid_i low inside a frame do not change the result. Frames may follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Final byte of the frame |
| rx_err_i | input | 1 | MAC bad-frame flag, meaningful with rx_last_i |
| rd_req_o | output | 1 | Read request pulse toward the transmit engine |
| ack_req_o | output | 1 | Acknowledge request pulse toward the transmit engine |
| evt_sn_o | output | 16 | Serial number of the last request |
| evt_vc_o | output | 2 | Channel of the last request |
| ack_size_o | output | 14 | Forwarded byte count for the acknowledge |
| ch_valid_o | output | 4 | Per-channel payload valid, at most one bit set |
| ch_data_o | output | 8 | Forwarded payload byte |
| ch_sof_o | output | 1 | First forwarded byte |
| ch_eof_o | output | 1 | Last forwarded byte, clean end |
| ch_eofe_o | output | 1 | Last forwarded byte, error end |

## Verification
Directed Write frames are sent with the size equal to, smaller than and larger than the received payload. These separate truncation at the size field from ending at the frame end, and each case shows whether the count in the acknowledge follows the bytes actually forwarded. Read frames are sent with a known serial number and channel, and also carrying stray payload, to show that nothing leaks onto the channel outputs. Boundary frames cover 13 against 14 bytes, a size of 8192 against 8193, a one-byte and a zero-byte payload, and a MAC error on the last payload byte against one arriving later. These show where dropping takes over from forwarding. Random frames with mixed types, channels, sizes, errors and idle gaps, plus one back-to-back pair, test the byte indexing against a stream that the bench models frame by frame.

// File: rtl/tfh_pkg.sv
package tfh_pkg;
  localparam int VC_W    = 2;
  localparam int PAY_OFS = 14;

  localparam logic [7:0] FT_NULL  = 8'h00;
  localparam logic [7:0] FT_POLL  = 8'h01;
  localparam logic [7:0] FT_WRITE = 8'h02;
  localparam logic [7:0] FT_READ  = 8'h03;

  typedef struct packed {
    logic [15:0]     sn;
    logic [7:0]      ftype;
    logic [VC_W-1:0] vc;
    logic            eofe;
    logic [15:0]     size;
  } hdr_t;
endpackage

// File: rtl/tfh_byte_idx.sv
module tfh_byte_idx #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idx_q <= '0;
    else if (valid_i && last_i)  idx_q <= '0;
    else if (valid_i && idx_q != '1) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/tfh_hdr_cap.sv
module tfh_hdr_cap
  import tfh_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic [IDX_W-1:0] idx_i,
  output hdr_t             hdr_o
);
  hdr_t hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
    end else if (valid_i) begin
      case (idx_i)
        IDX_W'(0): hdr_q.sn[15:8]   <= data_i;
        IDX_W'(1): hdr_q.sn[7:0]    <= data_i;
        IDX_W'(2): hdr_q.ftype      <= data_i;
        IDX_W'(3): begin
          hdr_q.vc   <= data_i[7:8-VC_W];
          hdr_q.eofe <= data_i[2];
        end
        IDX_W'(4): hdr_q.size[15:8] <= data_i;
        IDX_W'(5): hdr_q.size[7:0]  <= data_i;
        default: ;
      endcase
    end
  end

  assign hdr_o = hdr_q;
endmodule

// File: rtl/tfh_pay_demux.sv
module tfh_pay_demux
  import tfh_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [7:0]        data_i,
  input  logic [VC_W-1:0]   vc_i,
  input  logic              sof_i,
  input  logic              end_i,
  input  logic              eofe_i,
  output logic [NUM_VC-1:0] ch_valid_o,
  output logic [7:0]        ch_data_o,
  output logic              ch_sof_o,
  output logic              ch_eof_o,
  output logic              ch_eofe_o
);
  logic [NUM_VC-1:0] sel;

  for (genvar g = 0; g < NUM_VC; g++) begin : g_sel
    assign sel[g] = take_i && (vc_i == VC_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_valid_o <= '0;
      ch_data_o  <= '0;
      ch_sof_o   <= 1'b0;
      ch_eof_o   <= 1'b0;
      ch_eofe_o  <= 1'b0;
    end else begin
      ch_valid_o <= sel;
      ch_data_o  <= take_i ? data_i : '0;
      ch_sof_o   <= take_i && sof_i;
      ch_eof_o   <= take_i && end_i && !eofe_i;
      ch_eofe_o  <= take_i && end_i && eofe_i;
    end
  end

  // R4
  one_ch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_valid_o));
  // R6
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch_eof_o && ch_eofe_o));
  // R6
  mark_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_sof_o || ch_eof_o || ch_eofe_o) |-> (ch_valid_o != '0));
endmodule

// File: rtl/tunnel_hdr_rx.sv
module tunnel_hdr_rx
  import tfh_pkg::*;
#(
  parameter  int MAX_PAY = 8192,
  localparam int NUM_VC  = 1 << VC_W,
  localparam int SIZE_W  = $clog2(MAX_PAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  output logic              rd_req_o,
  output logic              ack_req_o,
  output logic [15:0]       evt_sn_o,
  output logic [VC_W-1:0]   evt_vc_o,
  output logic [SIZE_W-1:0] ack_size_o,
  output logic [NUM_VC-1:0] ch_valid_o,
  output logic [7:0]        ch_data_o,
  output logic              ch_sof_o,
  output logic              ch_eof_o,
  output logic              ch_eofe_o
);
  localparam int IDX_W = $clog2(PAY_OFS + 1);

  logic [IDX_W-1:0]  idx;
  hdr_t              hdr;
  logic [SIZE_W-1:0] fwd_cnt_q;
  logic size_ok, in_pay, room, take, pay_end, eofe_now;
  logic frame_end, long_enough, frame_good;

  tfh_byte_idx #(.IDX_W(IDX_W)) i_idx (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .last_i(rx_last_i), .idx_o(idx)
  );

  tfh_hdr_cap #(.IDX_W(IDX_W)) i_hdr (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .data_i(rx_data_i), .idx_i(idx), .hdr_o(hdr)
  );

  assign size_ok     = int'(hdr.size) <= MAX_PAY;
  assign in_pay      = idx >= IDX_W'(PAY_OFS);
  assign room        = int'(fwd_cnt_q) < int'(hdr.size);
  assign take        = rx_valid_i && in_pay && (hdr.ftype == FT_WRITE) && size_ok && room;
  // payload ends at the size limit or at frame end, whichever is first
  assign pay_end     = rx_last_i || (int'(fwd_cnt_q) + 1 == int'(hdr.size));
  assign eofe_now    = hdr.eofe || (rx_last_i && rx_err_i);
  assign frame_end   = rx_valid_i && rx_last_i;
  assign long_enough = idx >= IDX_W'(PAY_OFS - 1);
  assign frame_good  = frame_end && long_enough && !rx_err_i && size_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fwd_cnt_q <= '0;
    else if (frame_end) fwd_cnt_q <= '0;
    else if (take)      fwd_cnt_q <= fwd_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_req_o   <= 1'b0;
      ack_req_o  <= 1'b0;
      evt_sn_o   <= '0;
      evt_vc_o   <= '0;
      ack_size_o <= '0;
    end else begin
      rd_req_o  <= frame_good && (hdr.ftype == FT_READ);
      ack_req_o <= frame_good && (hdr.ftype == FT_WRITE);
      if (frame_good && (hdr.ftype == FT_READ || hdr.ftype == FT_WRITE)) begin
        evt_sn_o   <= hdr.sn;
        evt_vc_o   <= hdr.vc;
        ack_size_o <= (hdr.ftype == FT_WRITE) ? fwd_cnt_q + SIZE_W'(take) : '0;
      end
    end
  end

  tfh_pay_demux #(.NUM_VC(NUM_VC)) i_demux (
    .clk_i, .rst_ni,
    .take_i(take), .data_i(rx_data_i), .vc_i(hdr.vc),
    .sof_i(fwd_cnt_q == '0), .end_i(pay_end), .eofe_i(eofe_now),
    .ch_valid_o, .ch_data_o, .ch_sof_o, .ch_eof_o, .ch_eofe_o
  );

  // R3
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R7
  ack_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> $past(rx_valid_i && rx_last_i));
  // R3
  rd_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> $past(rx_valid_i && rx_last_i && !rx_err_i));
  // R11
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && ack_req_o));
  // R5
  ack_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> int'(ack_size_o) <= MAX_PAY);
endmodule

// File: tb/test_tunnel_hdr_rx.sv
module test_tunnel_hdr_rx;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rd_req, ack_req, ch_sof, ch_eof, ch_eofe;
  logic [15:0] evt_sn;
  logic [1:0]  evt_vc;
  logic [13:0] ack_size;
  logic [3:0]  ch_valid;
  logic [7:0]  ch_data;

  tunnel_hdr_rx i_tunnel_hdr_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_err_i(rx_err), .rd_req_o(rd_req), .ack_req_o(ack_req),
    .evt_sn_o(evt_sn), .evt_vc_o(evt_vc), .ack_size_o(ack_size),
    .ch_valid_o(ch_valid), .ch_data_o(ch_data), .ch_sof_o(ch_sof),
    .ch_eof_o(ch_eof), .ch_eofe_o(ch_eofe)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] frm[$];
  logic [7:0] cap_d[$];
  int cap_vc[$];
  int cap_f[$];
  int rd_n, ack_n, multi_n, rd_sn, rd_vc, ack_sn, ack_vc, ack_sz;

  always @(negedge clk) if (rst_n) begin
    if (ch_valid != '0) begin
      cap_d.push_back(ch_data);
      cap_vc.push_back(ch_valid[3] ? 3 : ch_valid[2] ? 2 : ch_valid[1] ? 1 : 0);
      cap_f.push_back({29'd0, ch_sof, ch_eof, ch_eofe});
      if ($countones(ch_valid) > 1) multi_n++;
    end
    if (rd_req)  begin rd_n++;  rd_sn = evt_sn; rd_vc = evt_vc; end
    if (ack_req) begin ack_n++; ack_sn = evt_sn; ack_vc = evt_vc; ack_sz = ack_size; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_cap();
    cap_d.delete(); cap_vc.delete(); cap_f.delete();
    rd_n = 0; ack_n = 0; multi_n = 0;
  endtask

  task automatic build(input int sn, input int ft, input int vc, input int ef, input int size, input int plen);
    frm.delete();
    frm.push_back(8'(sn >> 8)); frm.push_back(8'(sn));
    frm.push_back(8'(ft));
    frm.push_back(8'((vc << 6) | (ef ? 4 : 0) | 1));
    frm.push_back(8'(size >> 8)); frm.push_back(8'(size));
    for (int i = 0; i < 6; i++) frm.push_back(8'($urandom));
    frm.push_back(8'h88); frm.push_back(8'hb5);
    for (int i = 0; i < plen; i++) frm.push_back(8'($urandom));
  endtask

  task automatic drive(input int err, input int gaps);
    foreach (frm[i]) begin
      if (gaps != 0 && ($urandom % 3) == 0) begin
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1;
      rx_data  = frm[i];
      rx_last  = (i == frm.size() - 1);
      rx_err   = rx_last && (err != 0);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic run_frame(input string tag, input int sn, input int ft, input int vc,
                           input int ef, input int size, input int plen, input int err,
                           input int gaps, input int trunc);
    int tot, plen_e, fwd, mism, eofe_e;
    bit good, exp_rd, exp_ack, szok;
    clear_cap();
    build(sn, ft, vc, ef, size, plen);
    if (trunc >= 0) while (frm.size() > trunc) void'(frm.pop_back());
    tot = frm.size();
    drive(err, gaps);
    repeat (3) @(negedge clk);
    plen_e  = (tot >= 14) ? tot - 14 : 0;
    szok    = size <= 8192;
    good    = (tot >= 14) && szok && (err == 0);
    exp_rd  = good && ft == 3;
    exp_ack = good && ft == 2;
    fwd     = (ft == 2 && szok) ? ((size < plen_e) ? size : plen_e) : 0;
    eofe_e  = (ef != 0 || (err != 0 && plen_e <= size)) ? 1 : 0;
    chk(rd_n == int'(exp_rd), tag, "read request count", rd_n, int'(exp_rd));
    if (exp_rd && rd_n == 1) begin
      chk(rd_sn == sn, tag, "read serial", rd_sn, sn);
      chk(rd_vc == vc, tag, "read channel", rd_vc, vc);
    end
    chk(ack_n == int'(exp_ack), tag, "ack count", ack_n, int'(exp_ack));
    if (exp_ack && ack_n == 1) begin
      chk(ack_sn == sn, tag, "ack serial", ack_sn, sn);
      chk(ack_vc == vc, tag, "ack channel", ack_vc, vc);
      chk(ack_sz == fwd, tag, "ack size", ack_sz, fwd);
    end
    chk(cap_d.size() == fwd, tag, "forwarded count", cap_d.size(), fwd);
    if (fwd > 0 && cap_d.size() == fwd) begin
      mism = 0;
      for (int i = 0; i < fwd; i++) begin
        int ef_exp;
        ef_exp = ((i == 0) ? 4 : 0) |
                 ((i == fwd - 1 && eofe_e == 0) ? 2 : 0) |
                 ((i == fwd - 1 && eofe_e != 0) ? 1 : 0);
        if (cap_d[i] != frm[14 + i] || cap_vc[i] != vc || cap_f[i] != ef_exp) mism++;
      end
      chk(mism == 0, tag, "payload bytes/channel/markers mismatches", mism, 0);
    end
    chk(multi_n == 0, tag, "single channel valid", multi_n, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({rd_req, ack_req, evt_sn, evt_vc, ack_size, ch_valid, ch_data, ch_sof, ch_eof, ch_eofe} == '0,
        "R1", "outputs after reset", 1, 0);

    // R2 R3 read frame, big-endian serial
    run_frame("R2", 16'h12ab, 3, 2, 0, 0, 0, 0, 0, -1);
    run_frame("R3", 16'h0301, 3, 1, 0, 5, 5, 0, 0, -1);
    // R4 R5
    run_frame("R4", 16'h4444, 2, 1, 0, 10, 10, 0, 0, -1);
    run_frame("R5", 16'h5001, 2, 3, 0, 4, 9, 0, 0, -1);
    run_frame("R5", 16'h5002, 2, 0, 0, 12, 5, 0, 0, -1);
    // R6
    run_frame("R6", 16'h6001, 2, 2, 1, 6, 6, 0, 0, -1);
    run_frame("R6", 16'h6002, 2, 1, 0, 1, 1, 0, 0, -1);
    run_frame("R6", 16'h6003, 2, 3, 0, 7, 7, 1, 0, -1);
    run_frame("R6", 16'h6004, 2, 3, 0, 3, 8, 1, 0, -1);
    // R7 zero-size write
    run_frame("R7", 16'h7000, 2, 2, 0, 0, 4, 0, 0, -1);
    // R8
    run_frame("R8", 16'h8001, 3, 0, 0, 0, 0, 1, 0, -1);
    // R9
    run_frame("R9", 16'h9001, 2, 1, 0, 8193, 20, 0, 0, -1);
    run_frame("R9", 16'h9002, 2, 2, 0, 8192, 8192, 0, 0, -1);
    // R10
    run_frame("R10", 16'ha001, 3, 1, 0, 0, 0, 0, 0, 13);
    run_frame("R10", 16'ha002, 3, 1, 0, 0, 0, 0, 0, 14);
    run_frame("R10", 16'ha003, 2, 1, 0, 0, 0, 0, 0, 5);
    // R11
    run_frame("R11", 16'hb001, 0, 1, 0, 3, 3, 0, 0, -1);
    run_frame("R11", 16'hb002, 1, 2, 0, 3, 3, 0, 0, -1);
    run_frame("R11", 16'hb003, 7, 3, 0, 3, 3, 0, 0, -1);
    // R12 gaps
    run_frame("R12", 16'hc001, 2, 2, 0, 9, 9, 0, 1, -1);

    // R12 back-to-back writes
    begin
      logic [7:0] p1[$];
      int mism;
      clear_cap();
      build(16'hd001, 2, 0, 0, 3, 3);
      for (int i = 14; i < 17; i++) p1.push_back(frm[i]);
      drive(0, 0);
      build(16'hd002, 2, 3, 0, 2, 2);
      for (int i = 14; i < 16; i++) p1.push_back(frm[i]);
      drive(0, 0);
      repeat (3) @(negedge clk);
      chk(ack_n == 2, "R12", "back-to-back ack count", ack_n, 2);
      chk(ack_sn == 16'hd002, "R12", "second ack serial", ack_sn, 16'hd002);
      chk(cap_d.size() == 5, "R12", "back-to-back forwarded", cap_d.size(), 5);
      if (cap_d.size() == 5) begin
        mism = 0;
        for (int i = 0; i < 5; i++)
          if (cap_d[i] != p1[i] || cap_vc[i] != ((i < 3) ? 0 : 3)) mism++;
        chk(mism == 0, "R12", "back-to-back payload mismatches", mism, 0);
      end
    end

    // R4 random mix
    for (int n = 0; n < 40; n++) begin
      int ft, sz, pl;
      ft = $urandom % 5;
      sz = $urandom % 40;
      pl = $urandom % 40;
      run_frame("R4", int'($urandom % 65536), ft, int'($urandom % 4), int'($urandom % 2),
                sz, pl, (($urandom % 8) == 0) ? 1 : 0, int'($urandom % 2), -1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule